// File: doc/BRIEF.md
# Speculative Input Channel for a Five-Port Wormhole Router

This block is one input channel of a five-port wormhole router whose ports are east (X+), west (X-), north (Y+), south (Y-) and the local core. It sends flits across the crossbar before routing is known. While the channel has no packet in flight, it accepts a guessed output port from an external predictor and holds a reservation on that crossbar output. When a head flit reaches the front of the input FIFO, the channel pops it and sends it through the reserved port straight away. In the same cycle it computes the real output port with X-then-Y dimension-order routing, and compares that port with the guess.

If the guess was right, the head and every following flit of the packet leave on the reserved port at one flit per cycle. If the guess was wrong, the flit already sent is dead. The channel pulses a kill line on the wrong output, aligned with the dead flit. It then requests the correct output from the switch arbiter and resends the head from a holding register once the arbiter grants it. A head that arrives with no reservation takes this normal arbitration path at once. The predictor and the arbiter lie outside the block.

Top module: `pr_in_channel`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with no input activity, `resv`, `sw_req`, `st_valid` and `kill` are all zero and `fifo_pop` is low.
- R2: Port codes are 0 = X+, 1 = X-, 2 = Y+, 3 = Y-, 4 = local. One-hot vectors use bit index = port code. A prediction with a code from 0 to 4 that arrives while the channel is idle and the FIFO is empty shows up on `resv` as that one-hot port from the next cycle. Codes 5 to 7 are ignored and `resv` stays zero.
- R3: The correct port is chosen as follows. If the destination x is greater than the local x, the port is X+. If it is smaller, the port is X-. If x is equal, a greater y selects Y+, a smaller y selects Y-, and an equal y selects local.
- R4: With a reservation held, a head popped in cycle t appears on `st_valid` at the reserved port, with its flit on `st_flit`, in cycle t+1. If the guess matches the route, no kill and no switch request are raised.
- R5: After a correct guess, the body and tail flits leave on the same port one cycle after each is popped, back to back. `resv` stays on that port until the tail has been popped.
- R6: Predictions that arrive while a packet is in flight are ignored. In the cycle after the tail pop, `resv` is zero. A prediction still present then is taken one cycle later.
- R7: On a wrong guess, the dead head flit appears at the guessed port in cycle t+1 and `kill` pulses on that same port in that cycle only.
- R8: After a wrong guess, `sw_req` holds the correct port from cycle t+1 until `sw_grant` on that port. The head is resent on the correct port in the cycle after the grant, which is t+2 when the grant comes at once. No further flit is popped until the head has been resent.
- R9: A head that arrives while no reservation is held is not sent speculatively and raises no kill. It follows the switch-request path of R8.
- R10: The flit kind field is the top two bits of the flit: the upper bit marks a tail and the lower bit marks a head. A single-flit packet (both bits set) returns the channel to idle right after it is sent, on either path.
- R11: While waiting for a head, the reservation does not change, whatever the prediction inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_valid | input | 1 | Input FIFO has a flit at its front |
| fifo_flit | input | FLIT_W | Front flit: kind, destination x, destination y, payload (MSB first) |
| fifo_pop | output | 1 | Pops the front flit this cycle |
| pred_valid | input | 1 | Predictor offers a port |
| pred_port | input | 3 | Predicted port code |
| resv | output | 5 | One-hot crossbar reservation held by this channel |
| sw_req | output | 5 | One-hot request to the switch arbiter |
| sw_grant | input | 5 | One-hot grant from the switch arbiter |
| st_valid | output | 5 | One-hot output port carrying a flit this cycle |
| st_flit | output | FLIT_W | Flit on the crossbar |
| kill | output | 5 | One-hot discard pulse for a dead flit |

## Verification
The bench builds the channel with 3-bit coordinates, an 8-bit payload and the router placed at (2,2). With that placement, destinations on both sides of the router in each dimension, and equal to it, are all reachable, so every one of the five ports can be the routed result. Guesses are paired with destinations to give hits and misses on each port, and the miss cases include x-before-y conflicts. Packets of one to three flits exercise single-flit release and body streaming. A grant held back for several cycles shows that the request and the waiting body flits stay put.

// File: rtl/pr_pkg.sv
package pr_pkg;

    localparam int NPORT = 5;

    typedef enum logic [2:0] {
        P_XP  = 3'd0,
        P_XN  = 3'd1,
        P_YP  = 3'd2,
        P_YN  = 3'd3,
        P_LOC = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RESV,
        S_MISS,
        S_FWD
    } chan_st_e;

    function automatic logic [NPORT-1:0] port_oh(port_e p);
        logic [NPORT-1:0] v;
        v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

    function automatic logic port_code_ok(logic [2:0] c);
        return c < 3'(NPORT);
    endfunction

endpackage

// File: rtl/pr_xy_route.sv
module pr_xy_route
    import pr_pkg::*;
#(
    parameter int COORD_W = 4,
    parameter int MY_X    = 1,
    parameter int MY_Y    = 1
) (
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output port_e              route
);
    localparam logic [COORD_W-1:0] HERE_X = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] HERE_Y = COORD_W'(MY_Y);

    always_comb begin
        if (dst_x > HERE_X)      route = P_XP;
        else if (dst_x < HERE_X) route = P_XN;
        else if (dst_y > HERE_Y) route = P_YP;
        else if (dst_y < HERE_Y) route = P_YN;
        else                     route = P_LOC;
    end
endmodule

// File: rtl/pr_spec_ctrl.sv
module pr_spec_ctrl
    import pr_pkg::*;
#(
    parameter int FLIT_W = 42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_valid,
    input  logic [FLIT_W-1:0] fifo_flit,
    input  port_e             route,
    input  logic              pred_valid,
    input  logic [2:0]        pred_port,
    input  logic [NPORT-1:0]  sw_grant,
    output logic              fifo_pop,
    output logic [NPORT-1:0]  resv,
    output logic [NPORT-1:0]  sw_req,
    output logic              fire,
    output port_e             fire_port,
    output logic [FLIT_W-1:0] fire_flit,
    output logic              kill_en
);
    localparam int TAIL_BIT = FLIT_W - 1;

    chan_st_e          state_q, state_d;
    port_e             guess_q, guess_d;
    port_e             path_q, path_d;
    logic [FLIT_W-1:0] hold_q, hold_d;

    always_comb begin
        state_d   = state_q;
        guess_d   = guess_q;
        path_d    = path_q;
        hold_d    = hold_q;
        fifo_pop  = 1'b0;
        fire      = 1'b0;
        fire_port = path_q;
        fire_flit = fifo_flit;
        kill_en   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (fifo_valid) begin
                    fifo_pop = 1'b1;
                    hold_d   = fifo_flit;
                    path_d   = route;
                    state_d  = S_MISS;
                end else if (pred_valid && port_code_ok(pred_port)) begin
                    guess_d = port_e'(pred_port);
                    state_d = S_RESV;
                end
            end
            S_RESV: begin
                if (fifo_valid) begin
                    fifo_pop  = 1'b1;
                    fire      = 1'b1;
                    fire_port = guess_q;
                    if (route == guess_q) begin
                        path_d  = guess_q;
                        state_d = fifo_flit[TAIL_BIT] ? S_IDLE : S_FWD;
                    end else begin
                        kill_en = 1'b1;
                        hold_d  = fifo_flit;
                        path_d  = route;
                        state_d = S_MISS;
                    end
                end
            end
            S_MISS: begin
                if ((sw_grant & port_oh(path_q)) != '0) begin
                    fire      = 1'b1;
                    fire_flit = hold_q;
                    state_d   = hold_q[TAIL_BIT] ? S_IDLE : S_FWD;
                end
            end
            S_FWD: begin
                if (fifo_valid) begin
                    fifo_pop = 1'b1;
                    fire     = 1'b1;
                    if (fifo_flit[TAIL_BIT]) state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        resv   = '0;
        sw_req = '0;
        if (state_q == S_RESV)      resv   = port_oh(guess_q);
        else if (state_q == S_FWD)  resv   = port_oh(path_q);
        else if (state_q == S_MISS) sw_req = port_oh(path_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            guess_q <= P_LOC;
            path_q  <= P_LOC;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            guess_q <= guess_d;
            path_q  <= path_d;
            hold_q  <= hold_d;
        end
    end

    // R11: a held reservation only moves when a flit is popped
    a_r11_resv_steady: assert property (@(posedge clk) disable iff (rst)
        ((|$past(resv)) && !$past(fifo_pop)) |-> (resv == $past(resv)));

    // R2: at most one reserved port
    a_r2_resv_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(resv));
endmodule

// File: rtl/pr_st_stage.sv
module pr_st_stage
    import pr_pkg::*;
#(
    parameter int FLIT_W = 42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  port_e             fire_port,
    input  logic [FLIT_W-1:0] fire_flit,
    input  logic              kill_en,
    output logic [NPORT-1:0]  st_valid,
    output logic [FLIT_W-1:0] st_flit,
    output logic [NPORT-1:0]  kill
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st_valid <= '0;
            st_flit  <= '0;
            kill     <= '0;
        end else begin
            st_valid <= fire ? port_oh(fire_port) : '0;
            kill     <= kill_en ? port_oh(fire_port) : '0;
            if (fire) st_flit <= fire_flit;
        end
    end

    // R4: a flit leaves on one port at a time
    a_r4_one_port: assert property (@(posedge clk) disable iff (rst)
        $onehot0(st_valid));

    // R7: the kill is a single-cycle pulse
    a_r7_kill_pulse: assert property (@(posedge clk) disable iff (rst)
        (|kill) |=> (kill == '0));
endmodule

// File: rtl/pr_in_channel.sv
module pr_in_channel
    import pr_pkg::*;
#(
    parameter int COORD_W   = 4,
    parameter int PAYLOAD_W = 32,
    parameter int MY_X      = 1,
    parameter int MY_Y      = 1,
    localparam int FLIT_W   = 2 + 2 * COORD_W + PAYLOAD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_valid,
    input  logic [FLIT_W-1:0] fifo_flit,
    output logic              fifo_pop,
    input  logic              pred_valid,
    input  logic [2:0]        pred_port,
    output logic [4:0]        resv,
    output logic [4:0]        sw_req,
    input  logic [4:0]        sw_grant,
    output logic [4:0]        st_valid,
    output logic [FLIT_W-1:0] st_flit,
    output logic [4:0]        kill
);
    localparam int XMSB = FLIT_W - 3;
    localparam int YMSB = XMSB - COORD_W;

    port_e             route;
    logic              fire;
    port_e             fire_port;
    logic [FLIT_W-1:0] fire_flit;
    logic              kill_en;

    pr_xy_route #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
        .dst_x (fifo_flit[XMSB -: COORD_W]),
        .dst_y (fifo_flit[YMSB -: COORD_W]),
        .route (route)
    );

    pr_spec_ctrl #(.FLIT_W(FLIT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .fifo_valid (fifo_valid),
        .fifo_flit  (fifo_flit),
        .route      (route),
        .pred_valid (pred_valid),
        .pred_port  (pred_port),
        .sw_grant   (sw_grant),
        .fifo_pop   (fifo_pop),
        .resv       (resv),
        .sw_req     (sw_req),
        .fire       (fire),
        .fire_port  (fire_port),
        .fire_flit  (fire_flit),
        .kill_en    (kill_en)
    );

    pr_st_stage #(.FLIT_W(FLIT_W)) u_st (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .fire_port (fire_port),
        .fire_flit (fire_flit),
        .kill_en   (kill_en),
        .st_valid  (st_valid),
        .st_flit   (st_flit),
        .kill      (kill)
    );

    // R7/R8: a kill coincides with a request for a different port
    a_r8_kill_requests: assert property (@(posedge clk) disable iff (rst)
        (|kill) |-> ((sw_req != '0) && ((sw_req & kill) == '0)));

    // R8: a granted request sends the flit on that port next cycle
    a_r8_resend: assert property (@(posedge clk) disable iff (rst)
        (|(sw_req & sw_grant)) |=> (st_valid == $past(sw_req)));

    // R9: a reservation and a switch request never coexist
    a_r9_req_or_resv: assert property (@(posedge clk) disable iff (rst)
        !((|resv) && (|sw_req)));
endmodule

// File: tb/pr_in_channel_bench.sv
module pr_in_channel_bench;
    localparam int CW = 3;
    localparam int PW = 8;
    localparam int FW = 2 + 2 * CW + PW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fifo_valid, fifo_pop, pred_valid;
    logic [FW-1:0] fifo_flit, st_flit;
    logic [2:0]    pred_port;
    logic [4:0]    resv, sw_req, sw_grant, st_valid, kill;
    logic          grant_en;

    logic [FW-1:0] q [32];
    logic [4:0]    wr, rd;
    int            errs = 0;
    int            checks = 0;

    always #4 clk = ~clk;

    assign fifo_valid = (rd != wr);
    assign fifo_flit  = q[rd];
    assign sw_grant   = grant_en ? sw_req : 5'b0;

    always_ff @(posedge clk) begin
        if (rst) rd <= '0;
        else if (fifo_pop) rd <= rd + 5'd1;
    end

    pr_in_channel #(.COORD_W(CW), .PAYLOAD_W(PW), .MY_X(2), .MY_Y(2)) u_pr_in_channel (
        .clk(clk), .rst(rst), .fifo_valid(fifo_valid), .fifo_flit(fifo_flit),
        .fifo_pop(fifo_pop), .pred_valid(pred_valid), .pred_port(pred_port),
        .resv(resv), .sw_req(sw_req), .sw_grant(sw_grant), .st_valid(st_valid),
        .st_flit(st_flit), .kill(kill)
    );

    // {pred[13:11], dst_x[10:8], dst_y[7:5], extra flits[4:3], routed port[2:0]}, router at (2,2), R3
    localparam logic [13:0] VEC [12] = '{
        {3'd0, 3'd5, 3'd1, 2'd2, 3'd0},
        {3'd1, 3'd0, 3'd7, 2'd1, 3'd1},
        {3'd2, 3'd2, 3'd6, 2'd0, 3'd2},
        {3'd3, 3'd2, 3'd0, 2'd2, 3'd3},
        {3'd4, 3'd2, 3'd2, 2'd1, 3'd4},
        {3'd0, 3'd2, 3'd5, 2'd2, 3'd2},
        {3'd2, 3'd1, 3'd5, 2'd1, 3'd1},
        {3'd4, 3'd3, 3'd3, 2'd0, 3'd0},
        {3'd3, 3'd2, 3'd2, 2'd2, 3'd4},
        {3'd6, 3'd2, 3'd1, 2'd1, 3'd3},
        {3'd7, 3'd0, 3'd0, 2'd0, 3'd1},
        {3'd1, 3'd2, 3'd3, 2'd1, 3'd2}
    };

    function automatic logic [4:0] oh(int p);
        return (p < 5) ? (5'b1 << p) : 5'b0;
    endfunction

    function automatic logic [FW-1:0] mk(logic [1:0] kind, int x, int y, int pay);
        return {kind, 3'(x), 3'(y), 8'(pay)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(logic [FW-1:0] f);
        q[wr] = f;
        wr = wr + 5'd1;
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errs, checks);
    endtask

    // builds a packet of n flits into fl
    task automatic build(int n, int x, int y, int base, output logic [FW-1:0] fl [4]);
        for (int j = 0; j < 4; j++) fl[j] = '0;
        for (int j = 0; j < n; j++) begin
            logic [1:0] kd;
            if (n == 1)          kd = 2'b11;
            else if (j == 0)     kd = 2'b01;
            else if (j == n - 1) kd = 2'b10;
            else                 kd = 2'b00;
            fl[j] = mk(kd, x, y, base + j);
        end
    endtask

    task automatic run_vec(int vi);
        int p, x, y, n, e, mode;
        logic [FW-1:0] fl [4];
        p = int'(VEC[vi][13:11]); x = int'(VEC[vi][10:8]); y = int'(VEC[vi][7:5]);
        n = int'(VEC[vi][4:3]) + 1; e = int'(VEC[vi][2:0]);
        mode = (p > 4) ? 2 : ((p == e) ? 0 : 1);
        @(negedge clk); pred_valid = 1'b1; pred_port = 3'(p);
        @(negedge clk); pred_valid = 1'b0;
        chk("R2 reservation from prediction", 32'(resv), 32'(oh(p)));
        build(n, x, y, vi * 16, fl);
        for (int j = 0; j < n; j++) push(fl[j]);
        for (int k = 1; k <= n + 2; k++) begin
            logic [4:0]    esv, ekl;
            logic [FW-1:0] ef;
            @(negedge clk);
            esv = '0; ekl = '0; ef = '0;
            if (mode == 0) begin
                if (k <= n) begin esv = oh(p); ef = fl[k-1]; end
            end else begin
                if (mode == 1 && k == 1) begin esv = oh(p); ekl = oh(p); ef = fl[0]; end
                else if (k >= 2 && k <= n + 1) begin esv = oh(e); ef = fl[k-2]; end
            end
            if (mode == 0)      chk("R4 hit port", 32'(st_valid), 32'(esv));
            else if (mode == 1) chk("R3 routed port after miss", 32'(st_valid), 32'(esv));
            else                chk("R9 unreserved head port", 32'(st_valid), 32'(esv));
            chk("R7 kill line", 32'(kill), 32'(ekl));
            if (esv != '0) chk("R5 flit data", 32'(st_flit), 32'(ef));
            if (k == 1) begin
                chk("R8 switch request", 32'(sw_req), 32'((mode != 0) ? oh(e) : 5'b0));
                chk("R5 reservation held", 32'(resv), 32'((mode == 0 && n > 1) ? oh(p) : 5'b0));
            end
            if (k == n + 2) begin
                chk("R6/R10 released", 32'(resv), 32'd0);
                chk("R6 no request", 32'(sw_req), 32'd0);
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [FW-1:0] fl [4];
        for (int i = 0; i < 32; i++) q[i] = '0;
        wr = '0; pred_valid = 1'b0; pred_port = '0; grant_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 resv in reset", 32'(resv), 32'd0);
        chk("R1 st_valid in reset", 32'(st_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 resv after reset", 32'(resv), 32'd0);
        chk("R1 sw_req after reset", 32'(sw_req), 32'd0);
        chk("R1 kill after reset", 32'(kill), 32'd0);
        chk("R1 pop after reset", 32'(fifo_pop), 32'd0);

        for (int vi = 0; vi < 12; vi++) run_vec(vi);

        // R11: reservation unchanged by later predictions
        @(negedge clk); pred_valid = 1'b1; pred_port = 3'd1;
        @(negedge clk); pred_port = 3'd3;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R11 reservation steady", 32'(resv), 32'(oh(1)));
        end
        pred_valid = 1'b0;
        push(mk(2'b11, 0, 2, 8'hA1));
        @(negedge clk);
        chk("R11 hit on held port", 32'(st_valid), 32'(oh(1)));
        chk("R11 flit", 32'(st_flit), 32'(mk(2'b11, 0, 2, 8'hA1)));
        chk("R10 idle after single flit", 32'(resv), 32'd0);

        // R8: delayed grant keeps request, holds body flits
        grant_en = 1'b0;
        @(negedge clk); pred_valid = 1'b1; pred_port = 3'd0;
        @(negedge clk); pred_valid = 1'b0;
        build(2, 2, 0, 8'hB0, fl);
        push(fl[0]); push(fl[1]);
        @(negedge clk);
        chk("R7 dead flit on guess", 32'(st_valid), 32'(oh(0)));
        chk("R7 kill on guess", 32'(kill), 32'(oh(0)));
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R8 request waits", 32'(sw_req), 32'(oh(3)));
            chk("R8 nothing sent", 32'(st_valid), 32'd0);
            chk("R7 kill one cycle", 32'(kill), 32'd0);
        end
        grant_en = 1'b1;
        @(negedge clk);
        chk("R8 resend after grant", 32'(st_valid), 32'(oh(3)));
        chk("R8 resent head", 32'(st_flit), 32'(fl[0]));
        @(negedge clk);
        chk("R8 body follows", 32'(st_valid), 32'(oh(3)));
        chk("R8 body data", 32'(st_flit), 32'(fl[1]));

        // R6: prediction during a packet ignored until idle
        @(negedge clk); pred_valid = 1'b1; pred_port = 3'd0;
        @(negedge clk); pred_port = 3'd2;
        chk("R2 reservation", 32'(resv), 32'(oh(0)));
        build(3, 6, 2, 8'hC0, fl);
        push(fl[0]); push(fl[1]); push(fl[2]);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k <= 3) chk("R5 streamed flit", 32'(st_flit), 32'(fl[k-1]));
            if (k <= 2) chk("R6 held during packet", 32'(resv), 32'(oh(0)));
            if (k == 3) chk("R6 released after tail", 32'(resv), 32'd0);
            if (k == 4) chk("R6 new prediction taken", 32'(resv), 32'(oh(2)));
        end
        pred_valid = 1'b0;
        push(mk(2'b11, 2, 6, 8'hD1));
        @(negedge clk);
        chk("R4 hit after new prediction", 32'(st_valid), 32'(oh(2)));
        chk("R4 no request", 32'(sw_req), 32'd0);
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule